// File: doc/BRIEF.md
# UART Channel FIFO Status and DMA Request Logic

This block sits beside the serial shifters of one UART channel. It holds a receive queue and a transmit queue, each 32 characters deep by default. It derives the eight line-status bits, two active-low DMA request lines and the receive and transmit interrupt requests from how full those queues are. The host writes transmit bytes and reads received bytes through single-cycle strobes. The transmit shifter takes bytes from the head of the transmit queue. The receive shifter pushes each character together with its parity, framing and break flags.

When the queues are disabled, each one shrinks to a one-byte holding register. With the queues enabled, a mode input selects one of two request styles. In per-character mode the request lines follow the empty state of the queues directly. In block mode each request line is driven by a two-state machine with the states IDLE and BURST. The receive machine makes transition *start* from IDLE to BURST when the receive fill reaches the programmed trigger level. It makes transition *done* back to IDLE once the queue has drained to zero. The transmit machine makes *start* when the transmit fill is below half depth and *done* when the queue is full. Both machines are forced to IDLE whenever block mode is not selected.

Top module: `uart_fifo_status`

## Requirements
- R1: With the queues enabled, each queue holds up to 32 characters and returns them in arrival order on `host_rdata` (receive) and `tx_data` (transmit). A push or write into a full queue is dropped, and a pop of an empty queue has no effect.
- R2: With `fifo_en` low, each queue holds at most one character. Any change of `fifo_en` empties both queues at the clock edge where the new value is first sampled.
- R3: In per-character mode (`dma_mode` low, or `fifo_en` low), `txrdy_n` is 0 exactly when the transmit queue is empty.
- R4: In per-character mode, `rxrdy_n` is 0 exactly when the receive queue holds at least one character.
- R5: In block mode (`fifo_en` and `dma_mode` high), the receive machine enters BURST on the clock after the receive fill is at or above the trigger level. The trigger level is 8, 16, 24 or 28 for `rx_trig_sel` 0, 1, 2 or 3. The machine returns to IDLE on the clock after the fill is 0, and `rxrdy_n` is 0 exactly in BURST. Receive characters are still accepted above the trigger level until the queue is full.
- R6: In block mode, the transmit machine enters BURST on the clock after the transmit fill is below 16. It returns to IDLE on the clock after the fill is 32, and `txrdy_n` is 0 exactly in BURST.
- R7: `lsr[0]` is 1 while the receive queue is not empty. `lsr[5]` is 1 while the transmit queue is empty. `lsr[6]` is 1 when the transmit queue is empty and `tsr_empty` is 1.
- R8: While the receive queue is not empty, `lsr[2]`, `lsr[3]` and `lsr[4]` give the parity, framing and break flags of the character at its head; they are 0 when the queue is empty. `lsr[7]` is 1 while any stored receive character carries at least one of these flags.
- R9: `lsr[1]` becomes 1 after a receive push that finds the queue at capacity, and it stays 1 until a cycle with `lsr_rd` high and no new overrun.
- R10: `rx_flush` and `tx_flush` empty their queues on the next clock edge. A flush takes priority over a push or pop in the same cycle.
- R11: `rx_irq` = (`ier_bits[0]` and the receive fill is at or above the trigger level, or above 0 with the queues disabled) or (`ier_bits[2]` and any of `lsr[4:1]`). `tx_irq` = `ier_bits[1]` and an empty transmit queue. With `ier_bits` = 0 (polled mode) both stay 0 and the status stays readable in `lsr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1: 32-deep queues, 0: one-byte holding registers |
| dma_mode | input | 1 | 0: per-character requests, 1: block requests |
| rx_trig_sel | input | 2 | Receive trigger level select (8/16/24/28) |
| ier_bits | input | 3 | Enables: [0] receive data, [1] transmit empty, [2] line error |
| rx_flush | input | 1 | Strobe: empty the receive queue |
| tx_flush | input | 1 | Strobe: empty the transmit queue |
| host_wr | input | 1 | Strobe: host writes a transmit byte |
| host_wdata | input | 8 | Transmit byte from the host |
| host_rd | input | 1 | Strobe: host takes the receive head |
| host_rdata | output | 8 | Receive head character |
| lsr_rd | input | 1 | Strobe: host reads the line status (clears overrun) |
| tx_pop | input | 1 | Strobe: transmit shifter takes the head byte |
| tx_data | output | 8 | Transmit head byte |
| tsr_empty | input | 1 | Transmit shift register is idle |
| rx_push | input | 1 | Strobe: receive shifter delivers a character |
| rx_data | input | 8 | Received character |
| rx_perr | input | 1 | Parity error flag of the delivered character |
| rx_ferr | input | 1 | Framing error flag of the delivered character |
| rx_brk | input | 1 | Break flag of the delivered character |
| lsr | output | 8 | Line status bits |
| txrdy_n | output | 1 | Transmit DMA request, active low |
| rxrdy_n | output | 1 | Receive DMA request, active low |
| rx_irq | output | 1 | Receive interrupt request |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
The checker assumes that the strobes are single-cycle levels sampled at each rising edge. It does not assume the host avoids pushing into a full queue, popping an empty one or changing mode in the middle of traffic; the block has to absorb all of these. For that reason the random segments hold pop and push probabilities that range from starved to flooded, and they switch `fifo_en`, `dma_mode` and the trigger select between segments. The directed cases pin down the trigger crossings of both block-mode machines, the single-slot behaviour and a flush that collides with a push.

// File: rtl/ufs_pkg.sv
package ufs_pkg;

    localparam int unsigned UFS_DEPTH = 32;

    typedef enum logic [0:0] {
        DMA_IDLE  = 1'b0,
        DMA_BURST = 1'b1
    } dma_state_e;

    typedef struct packed {
        logic brk;
        logic ferr;
        logic perr;
    } rx_err_t;

    // Receive trigger fill for a two-bit select, scaled from the depth.
    function automatic int unsigned trig_fill(input logic [1:0] sel, input int unsigned depth);
        unique case (sel)
            2'd0:    return depth / 4;
            2'd1:    return depth / 2;
            2'd2:    return (3 * depth) / 4;
            default: return depth - depth / 8;
        endcase
    endfunction

endpackage

// File: rtl/ufs_fifo.sv
module ufs_fifo #(
    parameter  int DEPTH = 32,
    parameter  int WIDTH = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             do_push,
    input  logic             do_pop,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic [CW-1:0]    fill
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_q;
    logic [AW-1:0]    rd_q;
    logic [CW-1:0]    fill_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q   <= '0;
            rd_q   <= '0;
            fill_q <= '0;
        end else if (flush) begin
            wr_q   <= '0;
            rd_q   <= '0;
            fill_q <= '0;
        end else begin
            if (do_push) begin
                wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
            end
            if (do_pop) begin
                rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
            end
            fill_q <= fill_q + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_q] <= din;
        end
    end

    assign dout = mem[rd_q];
    assign fill = fill_q;

endmodule

// File: rtl/ufs_dma_fsm.sv
module ufs_dma_fsm
    import ufs_pkg::*;
#(
    parameter int CW    = 6,
    parameter bit IS_RX = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          blk_mode,
    input  logic [CW-1:0] fill,
    input  logic [CW-1:0] level,
    input  logic [CW-1:0] cap,
    output logic          burst
);

    dma_state_e state_q;
    dma_state_e state_d;
    logic       start_c;
    logic       done_c;

    generate
        if (IS_RX) begin : g_rx
            // receive: start at the trigger, run until drained
            assign start_c = (fill >= level);
            assign done_c  = (fill == '0);
        end else begin : g_tx
            // transmit: start below the level, run until full
            assign start_c = (fill < level);
            assign done_c  = (fill == cap);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DMA_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (!blk_mode) begin
            state_d = DMA_IDLE;
        end else begin
            unique case (state_q)
                DMA_IDLE:  if (start_c) state_d = DMA_BURST;
                DMA_BURST: if (done_c)  state_d = DMA_IDLE;
            endcase
        end
    end

    always_comb begin
        burst = (state_q == DMA_BURST);
    end

endmodule

// File: rtl/ufs_lsr.sv
module ufs_lsr
    import ufs_pkg::*;
#(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_clr,
    input  logic          rx_push,
    input  logic          rx_push_ok,
    input  logic          rx_pop_ok,
    input  logic          in_bad,
    input  rx_err_t       head_err,
    input  logic [CW-1:0] rx_fill,
    input  logic [CW-1:0] tx_fill,
    input  logic          tsr_empty,
    input  logic          lsr_rd,
    output logic [7:0]    lsr
);

    logic          ovr_q;
    logic [CW-1:0] bad_cnt_q;
    logic          rx_any;
    logic          tx_none;
    logic          head_bad;

    assign rx_any   = (rx_fill != '0);
    assign tx_none  = (tx_fill == '0);
    assign head_bad = |head_err;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
        end else if (rx_push && !rx_clr && !rx_push_ok) begin
            ovr_q <= 1'b1;
        end else if (lsr_rd) begin
            ovr_q <= 1'b0;
        end
    end

    // number of stored receive characters carrying any error flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bad_cnt_q <= '0;
        end else if (rx_clr) begin
            bad_cnt_q <= '0;
        end else begin
            bad_cnt_q <= bad_cnt_q + CW'(rx_push_ok && in_bad) - CW'(rx_pop_ok && head_bad);
        end
    end

    always_comb begin
        lsr[0]   = rx_any;
        lsr[1]   = ovr_q;
        lsr[2]   = rx_any && head_err.perr;
        lsr[3]   = rx_any && head_err.ferr;
        lsr[4]   = rx_any && head_err.brk;
        lsr[5]   = tx_none;
        lsr[6]   = tx_none && tsr_empty;
        lsr[7]   = (bad_cnt_q != '0);
    end

endmodule

// File: rtl/uart_fifo_status.sv
module uart_fifo_status
    import ufs_pkg::*;
#(
    parameter int DEPTH = UFS_DEPTH,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic             dma_mode,
    input  logic [1:0]       rx_trig_sel,
    input  logic [2:0]       ier_bits,
    input  logic             rx_flush,
    input  logic             tx_flush,
    input  logic             host_wr,
    input  logic [WIDTH-1:0] host_wdata,
    input  logic             host_rd,
    output logic [WIDTH-1:0] host_rdata,
    input  logic             lsr_rd,
    input  logic             tx_pop,
    output logic [WIDTH-1:0] tx_data,
    input  logic             tsr_empty,
    input  logic             rx_push,
    input  logic [WIDTH-1:0] rx_data,
    input  logic             rx_perr,
    input  logic             rx_ferr,
    input  logic             rx_brk,
    output logic [7:0]       lsr,
    output logic             txrdy_n,
    output logic             rxrdy_n,
    output logic             rx_irq,
    output logic             tx_irq
);

    localparam int            CW       = $clog2(DEPTH + 1);
    localparam int            RXW      = WIDTH + 3;
    localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
    localparam logic [CW-1:0] TX_LVL   = CW'(DEPTH / 2);

    logic            fifo_en_q;
    logic            en_flip;
    logic            rx_clr;
    logic            tx_clr;
    logic            blk_mode;
    logic [CW-1:0]   cap;
    logic [CW-1:0]   rx_level;
    logic [CW-1:0]   rx_fill;
    logic [CW-1:0]   tx_fill;
    logic            rx_do_push;
    logic            rx_do_pop;
    logic            tx_do_push;
    logic            tx_do_pop;
    logic [RXW-1:0]  rx_head;
    rx_err_t         head_err;
    logic            rx_burst;
    logic            tx_burst;
    logic            rx_hit;

    // a change of the queue enable empties both queues
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fifo_en_q <= 1'b0;
        end else begin
            fifo_en_q <= fifo_en;
        end
    end

    assign en_flip  = fifo_en ^ fifo_en_q;
    assign rx_clr   = rx_flush | en_flip;
    assign tx_clr   = tx_flush | en_flip;
    assign blk_mode = fifo_en & dma_mode;
    assign cap      = fifo_en ? FULL_LVL : CW'(1);
    assign rx_level = CW'(trig_fill(rx_trig_sel, DEPTH));

    assign rx_do_push = rx_push && !rx_clr && (rx_fill < cap);
    assign rx_do_pop  = host_rd && !rx_clr && (rx_fill != '0);
    assign tx_do_push = host_wr && !tx_clr && (tx_fill < cap);
    assign tx_do_pop  = tx_pop  && !tx_clr && (tx_fill != '0);

    ufs_fifo #(.DEPTH(DEPTH), .WIDTH(RXW)) u_rxq (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (rx_clr),
        .do_push (rx_do_push),
        .do_pop  (rx_do_pop),
        .din     ({rx_brk, rx_ferr, rx_perr, rx_data}),
        .dout    (rx_head),
        .fill    (rx_fill)
    );

    ufs_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_txq (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (tx_clr),
        .do_push (tx_do_push),
        .do_pop  (tx_do_pop),
        .din     (host_wdata),
        .dout    (tx_data),
        .fill    (tx_fill)
    );

    assign host_rdata = rx_head[WIDTH-1:0];
    assign head_err   = rx_err_t'(rx_head[RXW-1:WIDTH]);

    ufs_dma_fsm #(.CW(CW), .IS_RX(1'b1)) u_rx_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .blk_mode (blk_mode),
        .fill     (rx_fill),
        .level    (rx_level),
        .cap      (FULL_LVL),
        .burst    (rx_burst)
    );

    ufs_dma_fsm #(.CW(CW), .IS_RX(1'b0)) u_tx_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .blk_mode (blk_mode),
        .fill     (tx_fill),
        .level    (TX_LVL),
        .cap      (FULL_LVL),
        .burst    (tx_burst)
    );

    ufs_lsr #(.CW(CW)) u_lsr (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_clr     (rx_clr),
        .rx_push    (rx_push),
        .rx_push_ok (rx_do_push),
        .rx_pop_ok  (rx_do_pop),
        .in_bad     (rx_perr | rx_ferr | rx_brk),
        .head_err   (head_err),
        .rx_fill    (rx_fill),
        .tx_fill    (tx_fill),
        .tsr_empty  (tsr_empty),
        .lsr_rd     (lsr_rd),
        .lsr        (lsr)
    );

    assign txrdy_n = blk_mode ? !tx_burst : (tx_fill != '0);
    assign rxrdy_n = blk_mode ? !rx_burst : (rx_fill == '0);
    assign rx_hit  = fifo_en ? (rx_fill >= rx_level) : (rx_fill != '0);
    assign rx_irq  = (ier_bits[0] && rx_hit) || (ier_bits[2] && (|lsr[4:1]));
    assign tx_irq  = ier_bits[1] && (tx_fill == '0);

endmodule

// File: rtl/ufs_checker.sv
module ufs_checker #(
    parameter int DEPTH = 32,
    parameter int CW    = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fifo_en,
    input logic          dma_mode,
    input logic [CW-1:0] rx_fill,
    input logic [CW-1:0] tx_fill,
    input logic [CW-1:0] rx_level,
    input logic [2:0]    ier_bits,
    input logic          rx_flush,
    input logic          lsr_rd,
    input logic [7:0]    lsr,
    input logic          txrdy_n,
    input logic          rxrdy_n,
    input logic          rx_irq,
    input logic          tx_irq
);

    assert_fill_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_fill <= CW'(DEPTH)) && (tx_fill <= CW'(DEPTH)));

    assert_single_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && !$past(fifo_en)) |-> (rx_fill <= CW'(1)) && (tx_fill <= CW'(1)));

    assert_char_txrdy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_en && dma_mode) |-> (txrdy_n == !lsr[5]));

    assert_char_rxrdy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_en && dma_mode) |-> (rxrdy_n == !lsr[0]));

    assert_blk_rx_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && dma_mode && $past(fifo_en && dma_mode && (rx_fill >= rx_level))) |-> !rxrdy_n);

    assert_blk_tx_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && dma_mode && $past(fifo_en && dma_mode && (tx_fill < CW'(DEPTH / 2)))) |-> !txrdy_n);

    assert_shift_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lsr[6] |-> lsr[5]);

    assert_err_summary_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|lsr[4:2]) |-> lsr[7]);

    assert_ovr_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr[1] && !lsr_rd) |=> lsr[1]);

    assert_flush_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush |=> (rx_fill == '0));

    assert_polled_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_bits == 3'b000) |-> (!rx_irq && !tx_irq));

endmodule

bind uart_fifo_status ufs_checker #(.DEPTH(DEPTH), .CW(CW)) u_ufs_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fifo_en  (fifo_en),
    .dma_mode (dma_mode),
    .rx_fill  (rx_fill),
    .tx_fill  (tx_fill),
    .rx_level (rx_level),
    .ier_bits (ier_bits),
    .rx_flush (rx_flush),
    .lsr_rd   (lsr_rd),
    .lsr      (lsr),
    .txrdy_n  (txrdy_n),
    .rxrdy_n  (rxrdy_n),
    .rx_irq   (rx_irq),
    .tx_irq   (tx_irq)
);

// File: tb/uart_fifo_status_test.sv
`timescale 1ns/1ps
module uart_fifo_status_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b1;
    logic       dma_mode = 1'b0;
    logic [1:0] rx_trig_sel = 2'd0;
    logic [2:0] ier_bits = 3'b000;
    logic       rx_flush = 1'b0;
    logic       tx_flush = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic       host_rd = 1'b0;
    logic [7:0] host_rdata;
    logic       lsr_rd = 1'b0;
    logic       tx_pop = 1'b0;
    logic [7:0] tx_data;
    logic       tsr_empty = 1'b1;
    logic       rx_push = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rx_perr = 1'b0;
    logic       rx_ferr = 1'b0;
    logic       rx_brk = 1'b0;
    logic [7:0] lsr;
    logic       txrdy_n;
    logic       rxrdy_n;
    logic       rx_irq;
    logic       tx_irq;

    always #4 clk = ~clk;

    uart_fifo_status uut (.*);

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    int cyc = 0;

    // reference state
    logic [10:0] rxq[$];
    logic [7:0]  txq[$];
    bit m_ovr = 1'b0;
    bit m_rxb = 1'b0;
    bit m_txb = 1'b0;
    bit m_prev_en = 1'b0;

    function automatic int trig_of(input logic [1:0] sel);
        case (sel)
            2'd0: return 8;
            2'd1: return 16;
            2'd2: return 24;
            default: return 28;
        endcase
    endfunction

    function automatic logic [7:0] exp_lsr();
        logic [7:0] v = 8'h00;
        v[0] = (rxq.size() != 0);
        v[1] = m_ovr;
        if (rxq.size() != 0) v[4:2] = rxq[0][10:8];
        v[5] = (txq.size() == 0);
        v[6] = v[5] && tsr_empty;
        foreach (rxq[i]) if (rxq[i][10:8] != 3'b000) v[7] = 1'b1;
        return v;
    endfunction

    function automatic logic exp_txrdy_n();
        if (fifo_en && dma_mode) return !m_txb;
        return (txq.size() != 0);
    endfunction

    function automatic logic exp_rxrdy_n();
        if (fifo_en && dma_mode) return !m_rxb;
        return (rxq.size() == 0);
    endfunction

    function automatic logic exp_rx_irq();
        logic [7:0] v = exp_lsr();
        bit hit = fifo_en ? (rxq.size() >= trig_of(rx_trig_sel)) : (rxq.size() != 0);
        return (ier_bits[0] && hit) || (ier_bits[2] && (|v[4:1]));
    endfunction

    function automatic logic exp_tx_irq();
        return ier_bits[1] && (txq.size() == 0);
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // apply the inputs held at this edge to the reference state
    task automatic model_edge();
        int  rn = rxq.size();
        int  tn = txq.size();
        int  cap = fifo_en ? 32 : 1;
        bit  blk = fifo_en && dma_mode;
        bit  flip = (fifo_en != m_prev_en);
        bit  rclr = rx_flush || flip;
        bit  tclr = tx_flush || flip;
        if (!blk) begin
            m_rxb = 1'b0;
            m_txb = 1'b0;
        end else begin
            if (!m_rxb && rn >= trig_of(rx_trig_sel)) m_rxb = 1'b1;
            else if (m_rxb && rn == 0) m_rxb = 1'b0;
            if (!m_txb && tn < 16) m_txb = 1'b1;
            else if (m_txb && tn == 32) m_txb = 1'b0;
        end
        m_prev_en = fifo_en;
        if (rx_push && !rclr && rn >= cap) m_ovr = 1'b1;
        else if (lsr_rd) m_ovr = 1'b0;
        if (rclr) rxq.delete();
        else begin
            if (host_rd && rn != 0) void'(rxq.pop_front());
            if (rx_push && rn < cap) rxq.push_back({rx_brk, rx_ferr, rx_perr, rx_data});
        end
        if (tclr) txq.delete();
        else begin
            if (tx_pop && tn != 0) void'(txq.pop_front());
            if (host_wr && tn < cap) txq.push_back(host_wdata);
        end
    endtask

    task automatic compare();
        logic [7:0] el = exp_lsr();
        bit blk = fifo_en && dma_mode;
        string ttag = blk ? "R6" : "R3";
        string rtag = blk ? "R5" : "R4";
        chk("R7", "lsr[0] receive data", lsr[0], el[0]);
        chk("R9", "lsr[1] overrun", lsr[1], el[1]);
        chk("R8", "lsr[4:2] head flags", lsr[4:2], el[4:2]);
        chk("R8", "lsr[7] stored error", lsr[7], el[7]);
        chk("R7", "lsr[5] transmit empty", lsr[5], el[5]);
        chk("R7", "lsr[6] all idle", lsr[6], el[6]);
        chk(ttag, "txrdy_n", txrdy_n, exp_txrdy_n());
        chk(rtag, "rxrdy_n", rxrdy_n, exp_rxrdy_n());
        chk("R11", "rx_irq", rx_irq, exp_rx_irq());
        chk("R11", "tx_irq", tx_irq, exp_tx_irq());
        if (rxq.size() != 0) chk("R1", "host_rdata order", host_rdata, rxq[0][7:0]);
        if (txq.size() != 0) chk("R1", "tx_data order", tx_data, txq[0]);
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        #1;
        compare();
        @(negedge clk);
    endtask

    task automatic quiet();
        rx_flush = 1'b0; tx_flush = 1'b0; host_wr = 1'b0; host_rd = 1'b0;
        lsr_rd = 1'b0; tx_pop = 1'b0; rx_push = 1'b0;
        rx_perr = 1'b0; rx_ferr = 1'b0; rx_brk = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d cycles expected=finish", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // reset state
        chk("R7", "reset lsr", lsr, 8'h60);
        chk("R3", "reset txrdy_n", txrdy_n, 1'b0);
        chk("R4", "reset rxrdy_n", rxrdy_n, 1'b1);
        chk("R11", "reset irqs", {rx_irq, tx_irq}, 2'b00);
        rst_n = 1'b1;
        step();

        // R1 and R9: fill the receive queue past capacity
        ier_bits = 3'b001;
        for (int i = 0; i < 33; i++) begin
            rx_push = 1'b1; rx_data = 8'(i + 8'h40);
            step();
        end
        quiet();
        chk("R9", "overrun after 33rd push", lsr[1], 1'b1);
        chk("R1", "head is first push", host_rdata, 8'h40);
        lsr_rd = 1'b1; step(); quiet();
        chk("R9", "overrun cleared by status read", lsr[1], 1'b0);
        for (int i = 0; i < 32; i++) begin
            host_rd = 1'b1; step();
        end
        quiet();
        chk("R7", "receive empty after 32 reads", lsr[0], 1'b0);

        // R5: each trigger level in block mode
        dma_mode = 1'b1;
        for (int s = 0; s < 4; s++) begin
            int lvl;
            rx_trig_sel = 2'(s);
            lvl = trig_of(rx_trig_sel);
            rx_flush = 1'b1; step(); quiet();
            for (int i = 0; i < lvl - 1; i++) begin
                rx_push = 1'b1; rx_data = 8'(i); step();
            end
            quiet(); step();
            chk("R5", "rxrdy_n below trigger", rxrdy_n, 1'b1);
            rx_push = 1'b1; step(); quiet(); step();
            chk("R5", "rxrdy_n at trigger", rxrdy_n, 1'b0);
            for (int i = 0; i < lvl - 1; i++) begin
                host_rd = 1'b1; step();
            end
            quiet();
            chk("R5", "rxrdy_n held until drained", rxrdy_n, 1'b0);
            host_rd = 1'b1; step(); quiet(); step();
            chk("R5", "rxrdy_n released when empty", rxrdy_n, 1'b1);
        end

        // R6: transmit block requests
        tx_flush = 1'b1; step(); quiet(); step();
        chk("R6", "txrdy_n low when empty", txrdy_n, 1'b0);
        for (int i = 0; i < 32; i++) begin
            host_wr = 1'b1; host_wdata = 8'(8'hA0 + i); step();
        end
        quiet(); step();
        chk("R6", "txrdy_n high when full", txrdy_n, 1'b1);
        for (int i = 0; i < 16; i++) begin
            tx_pop = 1'b1; step();
        end
        quiet(); step();
        chk("R6", "txrdy_n high at half", txrdy_n, 1'b1);
        tx_pop = 1'b1; step(); quiet(); step();
        chk("R6", "txrdy_n low below half", txrdy_n, 1'b0);

        // R2: one-byte holding registers
        dma_mode = 1'b0; fifo_en = 1'b0;
        step();
        chk("R2", "disable empties transmit", lsr[5], 1'b1);
        rx_push = 1'b1; rx_data = 8'h11; step();
        rx_data = 8'h22; step(); quiet();
        chk("R2", "second byte overruns single slot", lsr[1], 1'b1);
        chk("R2", "single slot keeps first byte", host_rdata, 8'h11);
        host_wr = 1'b1; host_wdata = 8'h33; step();
        host_wdata = 8'h44; step(); quiet();
        chk("R2", "transmit slot keeps first byte", tx_data, 8'h33);
        chk("R3", "txrdy_n with holding byte", txrdy_n, 1'b1);
        lsr_rd = 1'b1; step(); quiet();
        fifo_en = 1'b1; step();
        chk("R2", "enable empties receive", lsr[0], 1'b0);
        chk("R2", "enable empties transmit", lsr[5], 1'b1);

        // R10: flush against simultaneous push
        for (int i = 0; i < 5; i++) begin
            rx_push = 1'b1; host_wr = 1'b1; step();
        end
        rx_flush = 1'b1; tx_flush = 1'b1; step(); quiet();
        chk("R10", "receive flush wins over push", lsr[0], 1'b0);
        chk("R10", "transmit flush wins over write", lsr[5], 1'b1);

        // R11 and R8: polled mode with an errored character
        ier_bits = 3'b000;
        rx_push = 1'b1; rx_perr = 1'b1; rx_data = 8'h5A; step();
        rx_perr = 1'b0; rx_brk = 1'b1; step(); quiet();
        chk("R11", "polled rx_irq quiet", rx_irq, 1'b0);
        chk("R8", "parity flag of head", lsr[4:2], 3'b001);
        ier_bits = 3'b100; #1;
        chk("R11", "line error interrupt", rx_irq, 1'b1);
        host_rd = 1'b1; step(); quiet();
        chk("R8", "break flag of next head", lsr[4:2], 3'b100);
        host_rd = 1'b1; step(); quiet();
        chk("R8", "no stored error after drain", lsr[7], 1'b0);

        // constrained random segments
        for (int seg = 0; seg < 40; seg++) begin
            int p_in;
            int p_out;
            fifo_en     = (($urandom % 8) != 0);
            dma_mode    = 1'($urandom % 2);
            rx_trig_sel = 2'($urandom % 4);
            ier_bits    = 3'($urandom % 8);
            p_in  = $urandom % 100;
            p_out = $urandom % 100;
            for (int c = 0; c < 100; c++) begin
                rx_push    = (($urandom % 100) < p_in);
                host_wr    = (($urandom % 100) < p_in);
                host_rd    = (($urandom % 100) < p_out);
                tx_pop     = (($urandom % 100) < p_out);
                rx_data    = 8'($urandom);
                host_wdata = 8'($urandom);
                rx_perr    = (($urandom % 8) == 0);
                rx_ferr    = (($urandom % 8) == 0);
                rx_brk     = (($urandom % 16) == 0);
                lsr_rd     = (($urandom % 10) == 0);
                rx_flush   = (($urandom % 150) == 0);
                tx_flush   = (($urandom % 150) == 0);
                tsr_empty  = 1'($urandom % 2);
                step();
            end
            quiet();
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule